// File: doc/BRIEF.md
# Tagged Capability Memory with Revocation Sweeper

This block is a slot-addressed memory in which each 64-bit slot carries one extra validity bit held in a separate flop vector, apart from the data array. A processor reaches it through a single request port offering four operations: plain load, plain store with byte enables, capability load and capability store. A plain store of any width leaves the slot untagged, so rewriting a capability's bit pattern with ordinary stores never produces a valid one. Only a capability store whose source operand is valid can set a slot's bit.

The block also holds a sweeper engine for revoking freed heap regions. Software hands it an address window, given as a lower bound and a length, together with a start pulse. The engine then visits every slot once and drops the validity bit of each stored capability whose base address lies inside that window. The sweeper works only in cycles when the processor port is idle. Its completion flag tells the allocator that the quarantined region may be handed out again.

The capability format is compact: the low 32 bits of a slot hold the base address that the sweeper tests against the window.

Top module: `tagged_mem_sweep`

## Requirements
- R1: After synchronous reset every slot's tag is 0, `rv_busy`, `rv_done` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: A plain store (op 1) updates only the bytes whose `req_wbe` bit is set (bit b covers data bits 8b+7..8b) and always leaves the slot's tag at 0.
- R3: A capability store (op 3) writes all 64 bits and sets the tag to `req_wtag`, so a store from an invalid source leaves the slot untagged.
- R4: An accepted load returns its result one cycle after acceptance with `rsp_valid` high. A capability load (op 2) returns data and tag. A plain load (op 0) returns data with `rsp_tag` at 0. No response appears without an accepted load.
- R5: A sweep clears the tag of every tagged slot whose base field (bits 31:0) lies in the window. Tags outside the window and all data bits are left as they were.
- R6: A base is in the window when base >= lower bound and base minus lower bound < length. A base equal to the lower bound is cleared, a base equal to bound plus length or one below the bound is kept, and a zero length clears nothing.
- R7: The sweeper examines at most one slot per cycle and only in cycles when `req_valid` is low. Processor requests take priority.
- R8: `req_ready` drops only for a request that addresses the slot the sweeper is examining in that cycle. The stalled request is accepted in the next cycle, and a capability stored then survives the sweep.
- R9: `rv_done` falls in the cycle after a sweep starts, stays low while `rv_busy` is high, rises when every slot has been examined, and holds until the next start. A start pulse during a sweep is ignored.
- R10: The window is captured at the start pulse. Changes on `rv_base` or `rv_len` during a sweep have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_op | input | 2 | 0 plain load, 1 plain store, 2 capability load, 3 capability store |
| req_addr | input | 8 | Slot index |
| req_wdata | input | 64 | Store data |
| req_wbe | input | 8 | Byte enables for plain stores |
| req_wtag | input | 1 | Validity of the source capability on a capability store |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 64 | Load data |
| rsp_tag | output | 1 | Tag of a capability load, 0 for a plain load |
| rv_start | input | 1 | Start pulse for a sweep |
| rv_base | input | 32 | Lower bound of the revoked window |
| rv_len | input | 32 | Length of the revoked window |
| rv_busy | output | 1 | Sweep in progress |
| rv_done | output | 1 | Last sweep complete, quarantine may be released |

## Verification
The hardest case to reach is a processor request that collides with the one slot the sweeper holds in its examine stage. That stage holds a slot for a single cycle, and the sweeper only moves forward while the port is idle. The bench gets there by keeping the port idle for exactly one cycle after the start pulse, so that slot 0 is under examination. It then sends a capability store to slot 0 and expects one stall cycle. It also checks that the freshly stored capability keeps its tag after the sweep. A start pulse and a window change issued in the middle of the sweep show that both the running sweep and its captured window go on unchanged.

// File: rtl/tagmem_pkg.sv
package tagmem_pkg;

    localparam int CAP_BITS  = 64;
    localparam int VA_BITS   = 32;
    localparam int NUM_SLOTS = 256;

    typedef enum logic [1:0] {
        OP_DLOAD  = 2'd0,
        OP_DSTORE = 2'd1,
        OP_CLOAD  = 2'd2,
        OP_CSTORE = 2'd3
    } mem_op_e;

    typedef struct packed {
        logic [VA_BITS-1:0] lo;
        logic [VA_BITS-1:0] len;
    } rv_window_t;

    function automatic logic is_load(input mem_op_e op);
        return (op == OP_DLOAD) || (op == OP_CLOAD);
    endfunction

    function automatic logic is_store(input mem_op_e op);
        return (op == OP_DSTORE) || (op == OP_CSTORE);
    endfunction

    function automatic logic [VA_BITS-1:0] cap_base(input logic [CAP_BITS-1:0] c);
        return c[VA_BITS-1:0];
    endfunction

    function automatic logic base_in_window(input logic [VA_BITS-1:0] b, input rv_window_t w);
        return (b >= w.lo) && ((b - w.lo) < w.len);
    endfunction

endpackage

// File: rtl/tm_slot_array.sv
module tm_slot_array
    import tagmem_pkg::*;
#(
    parameter int N_SLOTS = NUM_SLOTS,
    parameter int W       = CAP_BITS,
    localparam int AW     = $clog2(N_SLOTS),
    localparam int NB     = W / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_cap,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [NB-1:0] wr_be,
    input  logic          wr_tag,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_addr,
    input  logic [AW-1:0] pa_addr,
    output logic [W-1:0]  pa_data,
    output logic          pa_tag,
    input  logic [AW-1:0] sa_addr,
    output logic [W-1:0]  sa_data,
    output logic          sa_tag
);

    logic [W-1:0]       mem_q [N_SLOTS];
    logic [N_SLOTS-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_cap || wr_be[b]) begin
                    mem_q[wr_addr][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else begin
            if (clr_en) tag_q[clr_addr] <= 1'b0;
            if (wr_en)  tag_q[wr_addr]  <= wr_cap & wr_tag;
        end
    end

    assign pa_data = mem_q[pa_addr];
    assign pa_tag  = tag_q[pa_addr];
    assign sa_data = mem_q[sa_addr];
    assign sa_tag  = tag_q[sa_addr];

    assert_plain_store_untags_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_cap) |=> !tag_q[$past(wr_addr)]);

    assert_tags_only_from_valid_cap_R3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_cap && wr_tag) |=> ($countones(tag_q) <= $past($countones(tag_q))));

endmodule

// File: rtl/tm_sweeper.sv
module tm_sweeper
    import tagmem_pkg::*;
#(
    parameter int N_SLOTS = NUM_SLOTS,
    parameter int W       = CAP_BITS,
    parameter int VW      = VA_BITS,
    localparam int AW     = $clog2(N_SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [VW-1:0] win_lo,
    input  logic [VW-1:0] win_len,
    input  logic          port_busy,
    output logic [AW-1:0] look_addr,
    input  logic [W-1:0]  look_data,
    input  logic          look_tag,
    output logic          exam_valid,
    output logic [AW-1:0] exam_addr,
    output logic          clr_en,
    output logic          busy,
    output logic          done
);

    localparam logic [AW:0] SLOT_END = (AW+1)'(N_SLOTS);

    rv_window_t win_q;
    logic [AW:0] ptr_q;
    logic        hit_q;
    logic        issue;

    assign look_addr = ptr_q[AW-1:0];
    assign issue     = busy && !port_busy && (ptr_q < SLOT_END);
    assign clr_en    = exam_valid && hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            ptr_q      <= '0;
            exam_valid <= 1'b0;
            exam_addr  <= '0;
            hit_q      <= 1'b0;
            win_q      <= '0;
        end else begin
            exam_valid <= issue;
            if (!busy) begin
                if (start) begin
                    busy     <= 1'b1;
                    done     <= 1'b0;
                    ptr_q    <= '0;
                    win_q.lo  <= win_lo;
                    win_q.len <= win_len;
                end
            end else if (issue) begin
                exam_addr <= ptr_q[AW-1:0];
                hit_q     <= look_tag && base_in_window(cap_base(look_data), win_q);
                ptr_q     <= ptr_q + 1'b1;
            end else if (ptr_q == SLOT_END) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    assert_done_excludes_busy_R9: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_exam_only_in_sweep_R7: assert property (@(posedge clk) disable iff (rst)
        exam_valid |-> busy);

    assert_yield_to_port_R7: assert property (@(posedge clk) disable iff (rst)
        port_busy |=> !exam_valid);

    assert_start_drops_done_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done));

endmodule

// File: rtl/tagged_mem_sweep.sv
module tagged_mem_sweep
    import tagmem_pkg::*;
#(
    parameter int N_SLOTS = NUM_SLOTS,
    parameter int W       = CAP_BITS,
    parameter int VW      = VA_BITS,
    localparam int AW     = $clog2(N_SLOTS),
    localparam int NB     = W / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [W-1:0]  req_wdata,
    input  logic [NB-1:0] req_wbe,
    input  logic          req_wtag,
    output logic          rsp_valid,
    output logic [W-1:0]  rsp_data,
    output logic          rsp_tag,
    input  logic          rv_start,
    input  logic [VW-1:0] rv_base,
    input  logic [VW-1:0] rv_len,
    output logic          rv_busy,
    output logic          rv_done
);

    mem_op_e       op;
    logic          accept;
    logic          wr_en;
    logic [W-1:0]  pa_data;
    logic          pa_tag;
    logic [AW-1:0] look_addr;
    logic [W-1:0]  look_data;
    logic          look_tag;
    logic          exam_valid;
    logic [AW-1:0] exam_addr;
    logic          clr_en;

    assign op        = mem_op_e'(req_op);
    assign req_ready = !(exam_valid && req_valid && (req_addr == exam_addr));
    assign accept    = req_valid && req_ready;
    assign wr_en     = accept && is_store(op);

    tm_slot_array #(.N_SLOTS(N_SLOTS), .W(W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_cap   (op == OP_CSTORE),
        .wr_addr  (req_addr),
        .wr_data  (req_wdata),
        .wr_be    (req_wbe),
        .wr_tag   (req_wtag),
        .clr_en   (clr_en),
        .clr_addr (exam_addr),
        .pa_addr  (req_addr),
        .pa_data  (pa_data),
        .pa_tag   (pa_tag),
        .sa_addr  (look_addr),
        .sa_data  (look_data),
        .sa_tag   (look_tag)
    );

    tm_sweeper #(.N_SLOTS(N_SLOTS), .W(W), .VW(VW)) u_sweep (
        .clk        (clk),
        .rst        (rst),
        .start      (rv_start),
        .win_lo     (rv_base),
        .win_len    (rv_len),
        .port_busy  (req_valid),
        .look_addr  (look_addr),
        .look_data  (look_data),
        .look_tag   (look_tag),
        .exam_valid (exam_valid),
        .exam_addr  (exam_addr),
        .clr_en     (clr_en),
        .busy       (rv_busy),
        .done       (rv_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_tag   <= 1'b0;
        end else begin
            rsp_valid <= accept && is_load(op);
            if (accept && is_load(op)) begin
                rsp_data <= pa_data;
                rsp_tag  <= (op == OP_CLOAD) && pa_tag;
            end
        end
    end

    assert_load_answers_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && is_load(op)) |=> rsp_valid);

    assert_no_stray_response_R4: assert property (@(posedge clk) disable iff (rst)
        !(accept && is_load(op)) |=> !rsp_valid);

    assert_clear_never_races_write_R8: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> !(wr_en && (req_addr == exam_addr)));

    assert_plain_load_untagged_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_DLOAD) |=> !rsp_tag);

endmodule

// File: tb/tb_tagged_mem_sweep.sv
`timescale 1ns/1ps
module tb_tagged_mem_sweep;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [1:0]  req_op;
    logic [7:0]  req_addr;
    logic [63:0] req_wdata;
    logic [7:0]  req_wbe;
    logic        req_wtag;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        rsp_tag;
    logic        rv_start;
    logic [31:0] rv_base;
    logic [31:0] rv_len;
    logic        rv_busy;
    logic        rv_done;

    always #2 clk = ~clk;

    tagged_mem_sweep dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_wbe(req_wbe), .req_wtag(req_wtag),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
        .rv_start(rv_start), .rv_base(rv_base), .rv_len(rv_len),
        .rv_busy(rv_busy), .rv_done(rv_done)
    );

    typedef struct {
        logic [63:0] d;
        logic        t;
        bit          cmp_d;
        string       rq;
    } exp_t;

    exp_t        sb_q[$];
    logic [63:0] m_data [256];
    logic        m_tag  [256];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 0;

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb_q.size() == 0) begin
                chk("R4 unexpected response", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.cmp_d) chk({e.rq, " data"}, rsp_data, e.d);
                chk({e.rq, " tag"}, {63'd0, rsp_tag}, {63'd0, e.t});
            end
        end
    end

    function automatic bit in_win(input logic [31:0] b, input logic [31:0] lo, input logic [31:0] len);
        return (b >= lo) && ((b - lo) < len);
    endfunction

    task automatic access(input logic [1:0] op, input logic [7:0] a, input logic [63:0] d,
                          input logic [7:0] be, input logic tg, input bit cmp_d,
                          input string rq, output bit stalled);
        bit acc;
        stalled = 0;
        acc = 0;
        while (!acc) begin
            @(negedge clk);
            req_valid = 1; req_op = op; req_addr = a; req_wdata = d; req_wbe = be; req_wtag = tg;
            #1 acc = req_ready;
            if (!acc) stalled = 1;
            @(posedge clk);
        end
        case (op)
            2'd0: sb_q.push_back('{m_data[a], 1'b0, cmp_d, rq});
            2'd2: sb_q.push_back('{m_data[a], m_tag[a], cmp_d, rq});
            2'd1: begin
                for (int b = 0; b < 8; b++) if (be[b]) m_data[a][b*8 +: 8] = d[b*8 +: 8];
                m_tag[a] = 1'b0;
            end
            default: begin m_data[a] = d; m_tag[a] = tg; end
        endcase
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 0; rv_start = 0;
        end
    endtask

    task automatic start_sweep(input logic [31:0] lo, input logic [31:0] len);
        @(negedge clk);
        req_valid = 0; rv_start = 1; rv_base = lo; rv_len = len;
        @(posedge clk);
        for (int i = 0; i < 256; i++) if (m_tag[i] && in_win(m_data[i][31:0], lo, len)) m_tag[i] = 1'b0;
        @(negedge clk);
        rv_start = 0;
        #1;
        chk("R9 done low after start", {63'd0, rv_done}, 64'd0);
        chk("R9 busy after start", {63'd0, rv_busy}, 64'd1);
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (!rv_done && n < 2000) begin
            @(negedge clk);
            req_valid = 0;
            #1 n++;
        end
        chk("R9 sweep completes", {63'd0, rv_done}, 64'd1);
    endtask

    task automatic verify_slots(input string rq);
        bit s;
        for (int i = 0; i < 9; i++) access(2'd2, 8'(i), 64'd0, 8'd0, 1'b0, 1, rq, s);
        idle(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit s;
        rst = 1; req_valid = 0; req_op = 0; req_addr = 0; req_wdata = 0; req_wbe = 0; req_wtag = 0;
        rv_start = 0; rv_base = 0; rv_len = 0;
        for (int i = 0; i < 256; i++) begin m_data[i] = 'x; m_tag[i] = 1'b0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        chk("R1 busy reset", {63'd0, rv_busy}, 64'd0);
        chk("R1 done reset", {63'd0, rv_done}, 64'd0);
        chk("R1 rsp_valid reset", {63'd0, rsp_valid}, 64'd0);
        chk("R1 ready reset", {63'd0, req_ready}, 64'd1);
        access(2'd2, 8'd10, 64'd0, 8'd0, 1'b0, 0, "R1 tag after reset", s);
        access(2'd2, 8'd255, 64'd0, 8'd0, 1'b0, 0, "R1 tag after reset", s);

        access(2'd3, 8'd0, 64'hAAAA_0000_0000_1020, 8'd0, 1'b1, 0, "", s);
        access(2'd3, 8'd1, 64'h1111_0000_0000_1000, 8'd0, 1'b1, 0, "", s);
        access(2'd3, 8'd2, 64'h2222_0000_0000_10FF, 8'd0, 1'b1, 0, "", s);
        access(2'd3, 8'd3, 64'h3333_0000_0000_1100, 8'd0, 1'b1, 0, "", s);
        access(2'd3, 8'd4, 64'h4444_0000_0000_0FFF, 8'd0, 1'b1, 0, "", s);
        access(2'd3, 8'd5, 64'h5555_0000_0000_1080, 8'd0, 1'b0, 0, "", s);
        access(2'd3, 8'd6, 64'h6666_0000_0000_1040, 8'd0, 1'b1, 0, "", s);
        access(2'd1, 8'd6, 64'hFFFF_FFFF_FFFF_FF99, 8'h81, 1'b1, 0, "", s);
        access(2'd3, 8'd7, 64'h7777_0000_0000_5000, 8'd0, 1'b1, 0, "", s);
        access(2'd1, 8'd8, 64'h8888_0000_0000_1010, 8'hFF, 1'b1, 0, "", s);

        access(2'd2, 8'd6, 64'd0, 8'd0, 1'b0, 1, "R2 partial plain store merge and untag", s);
        access(2'd2, 8'd8, 64'd0, 8'd0, 1'b0, 1, "R2 full plain store untagged", s);
        access(2'd2, 8'd1, 64'd0, 8'd0, 1'b0, 1, "R3 valid capability store tagged", s);
        access(2'd2, 8'd5, 64'd0, 8'd0, 1'b0, 1, "R3 invalid source leaves untagged", s);
        access(2'd0, 8'd1, 64'd0, 8'd0, 1'b0, 1, "R4 plain load reports tag 0", s);
        access(2'd2, 8'd7, 64'd0, 8'd0, 1'b0, 1, "R4 capability load", s);
        idle(3);
        chk("R8 ready with no sweep", {63'd0, req_ready}, 64'd1);

        start_sweep(32'h0000_1000, 32'h0000_0100);
        access(2'd3, 8'd0, 64'hABCD_0000_0000_1030, 8'd0, 1'b1, 0, "", s);
        chk("R8 stall on examined slot", {63'd0, s}, 64'd1);
        access(2'd0, 8'd200, 64'd0, 8'd0, 1'b0, 0, "R7 load during sweep", s);
        chk("R8 no stall on other slot", {63'd0, s}, 64'd0);
        @(negedge clk);
        req_valid = 0; rv_start = 1; rv_base = 32'h0; rv_len = 32'hFFFF_FFFF;
        @(negedge clk);
        rv_start = 0;
        #1 chk("R9 busy unaffected by second start", {63'd0, rv_busy}, 64'd1);
        wait_done();
        verify_slots("R5 R6 R10 tags after first sweep");
        chk("R9 done holds", {63'd0, rv_done}, 64'd1);

        start_sweep(32'h0000_1100, 32'h0);
        wait_done();
        verify_slots("R6 zero-length window");

        start_sweep(32'h0, 32'hFFFF_FFFF);
        wait_done();
        verify_slots("R5 full window clears all");

        chk("R4 scoreboard drained", 64'(sb_q.size()), 64'd0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule